// File: doc/BRIEF.md
# I2C EEPROM Read Target

This block acts as a serial-memory target on a two-wire I2C bus and answers read transactions out of a small internal byte array. It recovers Start, repeated Start and Stop from the bus lines, which it oversamples with the system clock. It acknowledges a select byte that carries a fixed prefix, three chip-strap bits and a direction bit. In the write direction it takes a two-byte memory address into a single 16-bit address counter. It streams data bytes out in the read direction. The data line is open-drain, so the block only ever pulls it low, through an output enable.

A controller loads the counter with an address-only write that it closes with a repeated Start instead of a Stop. It then reads, in one of two ways. The first is a random read: the address-only write, then a read-direction select. The second is a current-address read: a read-direction select on its own, which starts from wherever the counter already points. Each finished byte moves the counter on by one. The controller acknowledges a byte to ask for the next one, and answers the last byte with no acknowledge.

Top module: `i2c_eeprom_rd`

## Requirements
- R1: The select byte is sent MSB first as 1010, then cs_strap_i[2:0], then the direction bit (1 = read). The target pulls SDA low in the acknowledge slot only when the first seven bits match. On a mismatch it never drives SDA until the next Start.
- R2: In the write direction the target acknowledges two address bytes, high byte first. When the low byte completes, both bytes load the 16-bit counter. The controller then sends a repeated Start and no Stop.
- R3: After it acknowledges a read-direction select, the target shifts out, MSB first, the byte at array index (counter mod DEPTH). After reset, the entry at index i holds (37*i + 11) mod 256.
- R4: The counter increases by one each time a data byte completes, and it wraps from 0xFFFF to 0x0000.
- R5: A read-direction select with no address phase returns the byte at the current counter value.
- R6: A controller acknowledge (SDA low) after a data byte brings the next byte. A no-acknowledge ends the data phase, SDA stays released, and the counter points past the last byte sent.
- R7: The level of wp_i, including changes to it, has no effect on any read transaction.
- R8: A Stop or a Start seen part-way through a byte abandons the transfer and returns the target to waiting for a select. The counter keeps its value.
- R9: The target changes sda_oe_o only while the synchronised SCL is low, and it leaves SDA released during the controller's acknowledge slot.
- R10: During and after reset, sda_oe_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level (wired-AND result) |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| cs_strap_i | input | 3 | Chip-select straps compared against the select byte |
| wp_i | input | 1 | Write-protect level, ignored for reads |

## Verification
The bench reads every array location and some addresses above DEPTH. It lays the high byte over several values, so a design that dropped or swapped an address byte, or failed to apply the modulo, would return wrong bytes. Sequential reads start at 0xFFFE, where a counter that failed to wrap or to increment would repeat bytes or return the wrong ones. The bench sends select bytes with the wrong prefix and with the wrong straps. A target that acknowledged them, or that disturbed the counter, would be caught by the current-address read that follows. Stops and Starts injected part-way through an address byte expose a design that loads a partial address or does not return to waiting for a select.

// File: rtl/i2c_rd_pkg.sv
package i2c_rd_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_SEL, ST_SEL_ACK, ST_AHI, ST_AHI_ACK,
    ST_ALO, ST_ALO_ACK, ST_TX, ST_TX_ACK, ST_SKIP
  } rd_state_e;

  localparam logic [3:0] SEL_PREFIX = 4'b1010;
  localparam int         CNT_W      = 16;
  localparam int         FILL_MUL   = 37;
  localparam int         FILL_ADD   = 11;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_o,
  output logic sda_o,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_sh, sda_sh;
  logic              scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_sh <= '1;
      sda_sh <= '1;
      scl_p  <= 1'b1;
      sda_p  <= 1'b1;
    end else begin
      scl_sh <= {scl_sh[STAGES-2:0], scl_i};
      sda_sh <= {sda_sh[STAGES-2:0], sda_i};
      scl_p  <= scl_sh[STAGES-1];
      sda_p  <= sda_sh[STAGES-1];
    end
  end

  assign scl_o     = scl_sh[STAGES-1];
  assign sda_o     = sda_sh[STAGES-1];
  assign scl_rise  = scl_o & ~scl_p;
  assign scl_fall  = ~scl_o & scl_p;
  assign start_evt = scl_o & scl_p & sda_p & ~sda_o;
  assign stop_evt  = scl_o & scl_p & ~sda_p & sda_o;
endmodule

// File: rtl/i2c_rd_mem.sv
module i2c_rd_mem
  import i2c_rd_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idx,
  output logic [7:0]    q
);
  logic [7:0] cells [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_cell
    localparam logic [7:0] FILL = 8'((g * FILL_MUL + FILL_ADD) % 256);
    logic [7:0] cell_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cell_q <= FILL;
      else        cell_q <= cell_q;
    end
    assign cells[g] = cell_q;
  end

  assign q = cells[idx];
endmodule

// File: rtl/i2c_rd_engine.sv
module i2c_rd_engine
  import i2c_rd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_evt,
  input  logic             stop_evt,
  input  logic             sda_s,
  input  logic [2:0]       strap,
  input  logic [7:0]       rd_data,
  output logic [CNT_W-1:0] cnt_q,
  output logic             sda_oe
);
  rd_state_e        st_q, st_d;
  logic [3:0]       bit_q, bit_d;
  logic [7:0]       sh_q, sh_d;
  logic [7:0]       hi_q, hi_d;
  logic [CNT_W-1:0] cnt_d;
  logic             oe_q, oe_d;
  logic             rw_q, rw_d;
  logic             nack_q, nack_d;

  always_comb begin
    st_d   = st_q;
    bit_d  = bit_q;
    sh_d   = sh_q;
    hi_d   = hi_q;
    cnt_d  = cnt_q;
    oe_d   = oe_q;
    rw_d   = rw_q;
    nack_d = nack_q;
    if (start_evt) begin
      st_d  = ST_SEL;
      bit_d = '0;
      oe_d  = 1'b0;
    end else if (stop_evt) begin
      st_d = ST_IDLE;
      oe_d = 1'b0;
    end else begin
      unique case (st_q)
        ST_SEL, ST_AHI, ST_ALO: begin
          if (scl_rise) begin
            sh_d  = {sh_q[6:0], sda_s};
            bit_d = bit_q + 4'd1;
          end else if (scl_fall && bit_q == 4'd8) begin
            bit_d = '0;
            if (st_q == ST_SEL) begin
              if (sh_q[7:1] == {SEL_PREFIX, strap}) begin
                oe_d = 1'b1;
                rw_d = sh_q[0];
                st_d = ST_SEL_ACK;
              end else begin
                st_d = ST_SKIP;
              end
            end else if (st_q == ST_AHI) begin
              hi_d = sh_q;
              oe_d = 1'b1;
              st_d = ST_AHI_ACK;
            end else begin
              cnt_d = {hi_q, sh_q};
              oe_d  = 1'b1;
              st_d  = ST_ALO_ACK;
            end
          end
        end
        ST_SEL_ACK: begin
          if (scl_fall) begin
            bit_d = '0;
            if (rw_q) begin
              sh_d = rd_data;
              oe_d = ~rd_data[7];
              st_d = ST_TX;
            end else begin
              oe_d = 1'b0;
              st_d = ST_AHI;
            end
          end
        end
        ST_AHI_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            st_d = ST_ALO;
          end
        end
        ST_ALO_ACK: begin
          if (scl_fall) begin
            oe_d = 1'b0;
            st_d = ST_SKIP;
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            bit_d = bit_q + 4'd1;
          end else if (scl_fall) begin
            if (bit_q == 4'd8) begin
              oe_d  = 1'b0;
              cnt_d = cnt_q + 1'b1;
              st_d  = ST_TX_ACK;
            end else begin
              sh_d = {sh_q[6:0], 1'b0};
              oe_d = ~sh_q[6];
            end
          end
        end
        ST_TX_ACK: begin
          if (scl_rise) begin
            nack_d = sda_s;
          end else if (scl_fall) begin
            bit_d = '0;
            if (!nack_q) begin
              sh_d = rd_data;
              oe_d = ~rd_data[7];
              st_d = ST_TX;
            end else begin
              st_d = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      bit_q  <= '0;
      sh_q   <= '0;
      hi_q   <= '0;
      cnt_q  <= '0;
      oe_q   <= 1'b0;
      rw_q   <= 1'b0;
      nack_q <= 1'b1;
    end else begin
      st_q   <= st_d;
      bit_q  <= bit_d;
      sh_q   <= sh_d;
      hi_q   <= hi_d;
      cnt_q  <= cnt_d;
      oe_q   <= oe_d;
      rw_q   <= rw_d;
      nack_q <= nack_d;
    end
  end

  assign sda_oe = oe_q;
endmodule

// File: rtl/i2c_eeprom_rd.sv
module i2c_eeprom_rd
  import i2c_rd_pkg::*;
#(
  parameter int DEPTH       = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe_o,
  input  logic [2:0] cs_strap_i,
  input  logic       wp_i
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, start_evt, stop_evt;
  logic [CNT_W-1:0] cnt_q;
  logic [7:0]       rd_data;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_o(scl_s), .sda_o(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2c_rd_mem #(.DEPTH(DEPTH)) u_mem (
    .clk(clk), .rst_n(rst_n), .idx(cnt_q[AW-1:0]), .q(rd_data)
  );

  i2c_rd_engine u_eng (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .strap(cs_strap_i), .rd_data(rd_data), .cnt_q(cnt_q), .sda_oe(sda_oe_o)
  );
endmodule

// File: rtl/i2c_eeprom_rd_chk.sv
module i2c_eeprom_rd_chk
  import i2c_rd_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             sda_oe,
  input logic             wp,
  input logic             start_evt,
  input logic             stop_evt,
  input logic             scl_fall,
  input rd_state_e        st,
  input logic [3:0]       bitcnt,
  input logic [CNT_W-1:0] cnt
);
  // R9
  sda_change_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_s);

  // R8
  stop_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> (st == ST_IDLE && !sda_oe));

  // R8
  abort_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_evt || stop_evt) |=> $stable(cnt));

  // R4
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_TX && scl_fall && bitcnt == 4'd8) |=> cnt == $past(cnt) + 16'd1);

  // R7
  wp_no_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(wp) && !scl_fall && !start_evt && !stop_evt) |=> $stable(sda_oe));

  // R1
  skip_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SKIP) |-> !sda_oe);
endmodule

bind i2c_eeprom_rd i2c_eeprom_rd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .sda_oe(sda_oe_o), .wp(wp_i),
  .start_evt(start_evt), .stop_evt(stop_evt), .scl_fall(scl_fall),
  .st(u_eng.st_q), .bitcnt(u_eng.bit_q), .cnt(cnt_q)
);

// File: tb/tb_i2c_eeprom_rd.sv
module tb_i2c_eeprom_rd;
  localparam int DEPTH = 32;
  localparam int QP    = 8;
  localparam logic [2:0] STRAP = 3'b101;
  localparam logic [7:0] SEL_W = {4'b1010, STRAP, 1'b0};
  localparam logic [7:0] SEL_R = {4'b1010, STRAP, 1'b1};

  logic clk, rst_n, scl_m, sda_m, wp;
  logic sda_oe;
  wire  sda_line = sda_m & ~sda_oe;

  int checks, errors;
  bit done;
  logic [15:0] exp_cnt;
  logic hi_oe;

  i2c_eeprom_rd #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .cs_strap_i(STRAP), .wp_i(wp)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [7:0] mexp(input logic [15:0] a);
    int idx;
    idx = int'(a) % DEPTH;
    return 8'((idx * 37 + 11) % 256);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic q();
    repeat (QP) @(negedge clk);
  endtask

  task automatic bus_bit(input logic b, output logic s);
    sda_m = b; q();
    scl_m = 1'b1; q();
    s = sda_line; hi_oe = sda_oe; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_start();
    sda_m = 1'b1; q();
    scl_m = 1'b1; q();
    sda_m = 1'b0; q();
    scl_m = 1'b0; q();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; q();
    scl_m = 1'b1; q();
    sda_m = 1'b1; q();
  endtask

  task automatic wbyte(input logic [7:0] b, output bit ack);
    logic s;
    for (int i = 7; i >= 0; i--) bus_bit(b[i], s);
    bus_bit(1'b1, s);
    ack = (s == 1'b0);
  endtask

  task automatic rbyte(input bit give_ack, output logic [7:0] d);
    logic s;
    d = '0;
    for (int i = 0; i < 8; i++) begin
      bus_bit(1'b1, s);
      d = {d[6:0], s};
    end
    bus_bit(give_ack ? 1'b0 : 1'b1, s);
  endtask

  task automatic read_bytes(input int n, input string tag);
    logic [7:0] d;
    for (int i = 0; i < n; i++) begin
      rbyte(i != n - 1, d);
      chk(d == mexp(exp_cnt), tag, int'(d), int'(mexp(exp_cnt)));
      exp_cnt = exp_cnt + 16'd1;
    end
    // R9: target released SDA in the controller's acknowledge slot
    chk(hi_oe == 1'b0, "R9 release in ack slot", int'(hi_oe), 0);
  endtask

  task automatic rand_read(input logic [15:0] a, input int n, input string tag);
    bit ack;
    bus_start();
    wbyte(SEL_W, ack); chk(ack, "R1 write select ack", int'(ack), 1);
    wbyte(a[15:8], ack); chk(ack, "R2 high address ack", int'(ack), 1);
    wbyte(a[7:0], ack);  chk(ack, "R2 low address ack", int'(ack), 1);
    bus_start();
    wbyte(SEL_R, ack); chk(ack, "R3 read select ack", int'(ack), 1);
    exp_cnt = a;
    read_bytes(n, tag);
    bus_stop();
  endtask

  task automatic cur_read(input int n, input string tag);
    bit ack;
    bus_start();
    wbyte(SEL_R, ack); chk(ack, "R5 read select ack", int'(ack), 1);
    read_bytes(n, tag);
    bus_stop();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    bit ack;
    logic s;
    logic [7:0] d;
    checks = 0; errors = 0; done = 0;
    scl_m = 1'b1; sda_m = 1'b1; wp = 1'b0; rst_n = 1'b0; hi_oe = 1'b0;
    exp_cnt = '0;
    repeat (5) @(negedge clk);
    // R10: released during reset
    chk(sda_oe == 1'b0, "R10 reset oe", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe == 1'b0, "R10 after reset oe", int'(sda_oe), 0);

    // R5: current read from the reset counter value
    cur_read(1, "R5 current read after reset");

    // R3 R7: every location plus addresses above DEPTH, high byte varied, wp toggled
    for (int a = 0; a < DEPTH + 4; a++) begin
      wp = a[0];
      rand_read(16'(a) + 16'(a << 9), 1, "R3/R7 random read");
    end

    // R5: current read continues after the last random read
    cur_read(1, "R5 current read follows counter");

    // R4 R6: sequential random read across 0xFFFF wrap
    wp = 1'b1;
    rand_read(16'hFFFE, 4, "R4/R6 sequential wrap");
    // R6: sequential current read
    wp = 1'b0;
    cur_read(3, "R6 sequential current read");

    // R1: wrong prefix is not acknowledged and the target stays silent
    bus_start();
    wbyte({4'b1011, STRAP, 1'b1}, ack);
    chk(!ack, "R1 wrong prefix no ack", int'(ack), 0);
    rbyte(1'b0, d);
    chk(d == 8'hFF, "R1 silent after mismatch", int'(d), 8'hFF);
    bus_stop();
    // R1: wrong straps are not acknowledged
    bus_start();
    wbyte({4'b1010, STRAP ^ 3'b001, 1'b1}, ack);
    chk(!ack, "R1 wrong strap no ack", int'(ack), 0);
    bus_stop();
    cur_read(1, "R1 counter untouched by ignored select");

    // R8: Stop part-way through the high address byte
    bus_start();
    wbyte(SEL_W, ack); chk(ack, "R8 select ack", int'(ack), 1);
    for (int i = 0; i < 4; i++) bus_bit(1'b0, s);
    bus_stop();
    cur_read(1, "R8 stop mid byte keeps counter");

    // R8: repeated Start part-way through the low address byte
    bus_start();
    wbyte(SEL_W, ack); chk(ack, "R8 select ack 2", int'(ack), 1);
    wbyte(8'h00, ack); chk(ack, "R8 high byte ack", int'(ack), 1);
    for (int i = 0; i < 3; i++) bus_bit(1'b1, s);
    bus_start();
    wbyte(SEL_R, ack); chk(ack, "R8 read select after abort", int'(ack), 1);
    read_bytes(1, "R8 start mid byte keeps counter");
    bus_stop();

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule